// File: doc/BRIEF.md
# Sliding-Window Cross-Correlation Updater

This block keeps a matrix of running cross-correlation sums between a vector of antipodal bits (one row per bit) and a vector of signed received samples (one column per sample). Once per bit period a start pulse hands it a new bit vector and sample vector, together with the pair that is leaving the observation window. The block then walks the matrix one element per cycle. Each element gets the signed sample added or subtracted according to the sign of the bit, so no multiplier is used. The walk can cover every row or only a contiguous range of rows, and a single-cycle pulse marks its end.

Two modes exist. In training mode the known pilot bits and the received pilot samples feed the update, and nothing is removed from the window. In tracking mode the detected bits and the delayed received data feed the update, and the contribution of the departing pair is also taken away. Each updated element saturates at the signed limits of the storage width. A synchronous clear zeroes the whole matrix before a new pilot sequence. A combinational read port serves the downstream consumer. One instance handles one real component of the samples; a second instance handles the imaginary part.

Top module: `slide_xcorr_acc`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: A `clr` pulse sets every element to zero from the next cycle onwards. It aborts a running walk without raising `done`, and it takes priority over a `start` in the same cycle.
- R3: Bit value 1 stands for +1 and 0 stands for -1. Samples are two's complement. Sample j sits at bits [SMP_W*j+SMP_W-1 : SMP_W*j] of a sample vector, and bit i of a bit vector belongs to row i. In training mode (`track_mode`=0) element (i,j) gains +r(j) when b(i)=1 and -r(j) when b(i)=0.
- R4: In tracking mode (`track_mode`=1) element (i,j) additionally loses +r0(j) when b0(i)=1, or -r0(j) when b0(i)=0, where b0 and r0 are `old_bits` and `old_smp`.
- R5: Training mode takes b and r from `pilot_bits` and `pilot_smp` and ignores the tracking inputs. Tracking mode takes them from `det_bits` and `data_smp` and ignores the pilot inputs.
- R6: The exact sum of the old value, the added term and the removed term is clamped once to [-2^(SMP_W-1), 2^(SMP_W-1)-1].
- R7: Only the rows from `row_first` through `row_last` are updated, across all columns. All other rows keep their values.
- R8: An accepted `start` raises `busy` on the next cycle. `busy` stays high for exactly (row_last-row_first+1)*COLS cycles. `done` is then high for one cycle, in the cycle in which `busy` has fallen.
- R9: A `start` is ignored while `busy` is high, and also when `row_first` > `row_last` or `row_last` >= ROWS.
- R10: All vectors, the mode and the row range are captured when `start` is accepted. Later changes on those inputs do not affect the walk that is running.
- R11: `rd_data` shows element (`rd_row`, `rd_col`) combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all elements |
| start | input | 1 | Begin one bit-period walk |
| track_mode | input | 1 | 0 training, 1 tracking |
| pilot_bits | input | ROWS | Known pilot bits |
| pilot_smp | input | COLS*SMP_W | Received pilot samples |
| det_bits | input | ROWS | Detected bits |
| data_smp | input | COLS*SMP_W | Delayed received data samples |
| old_bits | input | ROWS | Bits leaving the window |
| old_smp | input | COLS*SMP_W | Samples leaving the window |
| row_first | input | $clog2(ROWS) | First row of the walk |
| row_last | input | $clog2(ROWS) | Last row of the walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| rd_row | input | $clog2(ROWS) | Read row index |
| rd_col | input | $clog2(COLS) | Read column index |
| rd_data | output | SMP_W | Element at the read index |

## Verification
The assertions check the cycle-level control rules on every cycle. `done` is a single-cycle pulse that only follows a walk, a clear leaves the block idle with a zero read value, and an idle block with no start stays idle. The arithmetic is left to the bench scenarios: the sign-selected add, the removal term that applies only in tracking, the choice of input pair per mode, the single clamp, the row-range restriction and the capture of inputs at start. The bench checks these by reading back the whole matrix against its own model after each walk, including pinned saturation patterns and walks disturbed by a clear or a second start.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef enum logic {
    SRC_TRAIN = 1'b0,
    SRC_TRACK = 1'b1
  } src_mode_e;

  typedef enum logic {
    SW_IDLE  = 1'b0,
    SW_WALK  = 1'b1
  } sweep_st_e;
endpackage

// File: rtl/xc_src_sel.sv
module xc_src_sel #(
  parameter int ROWS  = 64,
  parameter int COLS  = 32,
  parameter int SMP_W = 8,
  localparam int VW   = COLS * SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             mode,
  input  logic [ROWS-1:0]  pilot_bits,
  input  logic [VW-1:0]    pilot_smp,
  input  logic [ROWS-1:0]  det_bits,
  input  logic [VW-1:0]    data_smp,
  input  logic [ROWS-1:0]  old_bits,
  input  logic [VW-1:0]    old_smp,
  output logic             trk_q,
  output logic [ROWS-1:0]  new_bits_q,
  output logic [VW-1:0]    new_smp_q,
  output logic [ROWS-1:0]  rem_bits_q,
  output logic [VW-1:0]    rem_smp_q
);
  import sxc_pkg::*;

  logic [ROWS-1:0] bits_mux;
  logic [VW-1:0]   smp_mux;

  always_comb begin
    if (src_mode_e'(mode) == SRC_TRACK) begin
      bits_mux = det_bits;
      smp_mux  = data_smp;
    end else begin
      bits_mux = pilot_bits;
      smp_mux  = pilot_smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q      <= 1'b0;
      new_bits_q <= '0;
      new_smp_q  <= '0;
      rem_bits_q <= '0;
      rem_smp_q  <= '0;
    end else if (capture) begin
      trk_q      <= mode;
      new_bits_q <= bits_mux;
      new_smp_q  <= smp_mux;
      rem_bits_q <= old_bits;
      rem_smp_q  <= old_smp;
    end
  end
endmodule

// File: rtl/xc_sweep_ctrl.sv
module xc_sweep_ctrl #(
  parameter int ROWS = 64,
  parameter int COLS = 32,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic [RW-1:0] row_first,
  input  logic [RW-1:0] row_last,
  output logic          capture,
  output logic          wr_en,
  output logic [RW-1:0] row_q,
  output logic [CW-1:0] col_q,
  output logic          busy,
  output logic          done
);
  import sxc_pkg::*;

  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_MAX = CW'(COLS - 1);

  sweep_st_e     st_q, st_n;
  logic [RW-1:0] row_n, last_q, last_n;
  logic [CW-1:0] col_n;
  logic          done_q, done_n;
  logic          range_ok;

  assign range_ok = (row_first <= row_last) && (row_last <= ROW_MAX);
  assign capture  = start && !clr && (st_q == SW_IDLE) && range_ok;
  assign wr_en    = (st_q == SW_WALK) && !clr;
  assign busy     = (st_q == SW_WALK);
  assign done     = done_q;

  always_comb begin
    st_n   = st_q;
    row_n  = row_q;
    col_n  = col_q;
    last_n = last_q;
    done_n = 1'b0;
    if (clr) begin
      st_n = SW_IDLE;
    end else if (capture) begin
      st_n   = SW_WALK;
      row_n  = row_first;
      col_n  = '0;
      last_n = row_last;
    end else if (st_q == SW_WALK) begin
      if (col_q == COL_MAX) begin
        col_n = '0;
        if (row_q == last_q) begin
          st_n   = SW_IDLE;
          done_n = 1'b1;
        end else begin
          row_n = row_q + 1'b1;
        end
      end else begin
        col_n = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      row_q  <= row_n;
      col_q  <= col_n;
      last_q <= last_n;
      done_q <= done_n;
    end
  end
endmodule

// File: rtl/xc_elem_update.sv
module xc_elem_update #(
  parameter int SMP_W = 8
) (
  input  logic             trk,
  input  logic [SMP_W-1:0] acc,
  input  logic             b_new,
  input  logic [SMP_W-1:0] s_new,
  input  logic             b_old,
  input  logic [SMP_W-1:0] s_old,
  output logic [SMP_W-1:0] acc_next
);
  localparam int XW = SMP_W + 2;
  localparam logic signed [XW-1:0] HI = XW'((2 ** (SMP_W - 1)) - 1);
  localparam logic signed [XW-1:0] LO = -HI - XW'(1);

  logic signed [XW-1:0] acc_x, add_x, rem_x, sum_x;
  logic signed [XW-1:0] sn_x, so_x;

  always_comb begin
    acc_x = {{2{acc[SMP_W-1]}}, acc};
    sn_x  = {{2{s_new[SMP_W-1]}}, s_new};
    so_x  = {{2{s_old[SMP_W-1]}}, s_old};
    add_x = b_new ? sn_x : -sn_x;
    if (trk) rem_x = b_old ? so_x : -so_x;
    else     rem_x = '0;
    sum_x = acc_x + add_x - rem_x;
    if (sum_x > HI)      acc_next = HI[SMP_W-1:0];
    else if (sum_x < LO) acc_next = LO[SMP_W-1:0];
    else                 acc_next = sum_x[SMP_W-1:0];
  end
endmodule

// File: rtl/xc_mat_store.sv
module xc_mat_store #(
  parameter int ROWS  = 64,
  parameter int COLS  = 32,
  parameter int SMP_W = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_row,
  input  logic [CW-1:0]    wr_col,
  input  logic [SMP_W-1:0] wr_data,
  output logic [SMP_W-1:0] upd_rd,
  input  logic [RW-1:0]    rd_row,
  input  logic [CW-1:0]    rd_col,
  output logic [SMP_W-1:0] rd_data
);
  logic [SMP_W-1:0] mem [ROWS][COLS];

  assign upd_rd  = mem[wr_row][wr_col];
  assign rd_data = mem[rd_row][rd_col];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c] <= '0;
    end else if (wr_en) begin
      mem[wr_row][wr_col] <= wr_data;
    end
  end
endmodule

// File: rtl/slide_xcorr_acc.sv
module slide_xcorr_acc #(
  parameter int ROWS  = 64,
  parameter int COLS  = 32,
  parameter int SMP_W = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS),
  localparam int VW   = COLS * SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             track_mode,
  input  logic [ROWS-1:0]  pilot_bits,
  input  logic [VW-1:0]    pilot_smp,
  input  logic [ROWS-1:0]  det_bits,
  input  logic [VW-1:0]    data_smp,
  input  logic [ROWS-1:0]  old_bits,
  input  logic [VW-1:0]    old_smp,
  input  logic [RW-1:0]    row_first,
  input  logic [RW-1:0]    row_last,
  output logic             busy,
  output logic             done,
  input  logic [RW-1:0]    rd_row,
  input  logic [CW-1:0]    rd_col,
  output logic [SMP_W-1:0] rd_data
);
  logic             capture, mem_we, trk_q;
  logic [RW-1:0]    row_q;
  logic [CW-1:0]    col_q;
  logic [ROWS-1:0]  new_bits_q, rem_bits_q;
  logic [VW-1:0]    new_smp_q, rem_smp_q;
  logic [SMP_W-1:0] acc_cur, acc_nxt;

  xc_sweep_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start),
    .row_first(row_first), .row_last(row_last),
    .capture(capture), .wr_en(mem_we), .row_q(row_q), .col_q(col_q),
    .busy(busy), .done(done)
  );

  xc_src_sel #(.ROWS(ROWS), .COLS(COLS), .SMP_W(SMP_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .capture(capture), .mode(track_mode),
    .pilot_bits(pilot_bits), .pilot_smp(pilot_smp),
    .det_bits(det_bits), .data_smp(data_smp),
    .old_bits(old_bits), .old_smp(old_smp),
    .trk_q(trk_q), .new_bits_q(new_bits_q), .new_smp_q(new_smp_q),
    .rem_bits_q(rem_bits_q), .rem_smp_q(rem_smp_q)
  );

  xc_elem_update #(.SMP_W(SMP_W)) u_upd (
    .trk(trk_q), .acc(acc_cur),
    .b_new(new_bits_q[row_q]), .s_new(new_smp_q[col_q*SMP_W +: SMP_W]),
    .b_old(rem_bits_q[row_q]), .s_old(rem_smp_q[col_q*SMP_W +: SMP_W]),
    .acc_next(acc_nxt)
  );

  xc_mat_store #(.ROWS(ROWS), .COLS(COLS), .SMP_W(SMP_W)) u_mem (
    .clk(clk), .clr(clr), .wr_en(mem_we), .wr_row(row_q), .wr_col(col_q),
    .wr_data(acc_nxt), .upd_rd(acc_cur),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );
endmodule

// File: rtl/sxc_checker.sv
module sxc_checker #(
  parameter int SMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [SMP_W-1:0] rd_data
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R8

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_data == '0)); // R2

  AST_CLEAR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !done)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy); // R9
endmodule

bind slide_xcorr_acc sxc_checker #(.SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .start(start),
  .busy(busy), .done(done), .rd_data(rd_data)
);

// File: tb/slide_xcorr_acc_tb.sv
module slide_xcorr_acc_tb;
  localparam int ROWS = 8;
  localparam int COLS = 4;
  localparam int W    = 8;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);
  localparam int VW   = COLS * W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n, clr, start, track_mode, busy, done;
  logic [ROWS-1:0] pilot_bits, det_bits, old_bits;
  logic [VW-1:0]   pilot_smp, data_smp, old_smp;
  logic [RW-1:0]   row_first, row_last, rd_row;
  logic [CW-1:0]   rd_col;
  logic [W-1:0]    rd_data;

  slide_xcorr_acc #(.ROWS(ROWS), .COLS(COLS), .SMP_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .track_mode(track_mode),
    .pilot_bits(pilot_bits), .pilot_smp(pilot_smp), .det_bits(det_bits),
    .data_smp(data_smp), .old_bits(old_bits), .old_smp(old_smp),
    .row_first(row_first), .row_last(row_last), .busy(busy), .done(done),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  int model [ROWS][COLS];
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  function automatic int term(input logic b, input logic [W-1:0] s);
    int v;
    v = int'($signed(s));
    return b ? v : -v;
  endfunction

  function automatic int clampv(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) begin
        @(negedge clk);
        rd_row = RW'(i);
        rd_col = CW'(j);
        #1;
        check(req, int'($signed(rd_data)), model[i][j]);
      end
  endtask

  task automatic zero_model();
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) model[i][j] = 0;
  endtask

  task automatic scramble();
    pilot_bits = ROWS'($urandom); det_bits = ROWS'($urandom); old_bits = ROWS'($urandom);
    pilot_smp = $urandom; data_smp = $urandom; old_smp = $urandom;
  endtask

  // one walk using the vectors currently on the inputs
  task automatic run_period(input logic mode, input int first, input int last,
                            input bit extra_start, input string req);
    int cnt, guard;
    logic [ROWS-1:0] nb;
    logic [VW-1:0]   ns;
    @(negedge clk);
    track_mode = mode;
    row_first  = RW'(first);
    row_last   = RW'(last);
    start      = 1'b1;
    nb = mode ? det_bits : pilot_bits;   // R5 selection
    ns = mode ? data_smp : pilot_smp;
    for (int i = first; i <= last; i++)
      for (int j = 0; j < COLS; j++)
        model[i][j] = clampv(model[i][j] + term(nb[i], ns[j*W +: W])
                      - (mode ? term(old_bits[i], old_smp[j*W +: W]) : 0));
    @(negedge clk);
    start = 1'b0;
    scramble();            // R10: changes after capture must not matter
    track_mode = ~mode;
    cnt = 0;
    guard = 0;
    while (!done && guard < 1000) begin
      if (busy) cnt++;
      if (extra_start && cnt == 2) begin
        start = 1'b1; row_first = '0; row_last = RW'(ROWS - 1);  // R9 ignored while busy
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check("R8 busy length", cnt, (last - first + 1) * COLS);
    check("R8 done seen", int'(done), 1);
    check("R8 busy low with done", int'(busy), 0);
    @(negedge clk);
    check("R8 done width", int'(done), 0);
    compare_all(req);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    zero_model();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual no completion expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    rst_n = 1'b0; clr = 1'b0; start = 1'b0; track_mode = 1'b0;
    row_first = '0; row_last = '0; rd_row = '0; rd_col = '0;
    scramble();
    repeat (3) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
    rst_n = 1'b1;

    do_clear();
    compare_all("R2 clear to zero");

    // R6 positive clamp: training, all +1 bits, samples 127
    pilot_bits = '1; pilot_smp = {COLS{8'h7F}};
    run_period(1'b0, 0, ROWS - 1, 1'b0, "R3 training add");
    pilot_bits = '1; pilot_smp = {COLS{8'h7F}};
    run_period(1'b0, 0, ROWS - 1, 1'b0, "R6 clamp high");
    // R4/R6: tracking, large positive exact sum
    det_bits = '0; data_smp = {COLS{8'h80}}; old_bits = '0; old_smp = {COLS{8'h7F}};
    run_period(1'b1, 0, ROWS - 1, 1'b0, "R4 R6 tracking clamp high");

    do_clear();
    pilot_bits = '0; pilot_smp = {COLS{8'h7F}};
    run_period(1'b0, 0, ROWS - 1, 1'b0, "R3 training subtract");
    pilot_bits = '0; pilot_smp = {COLS{8'h7F}};
    run_period(1'b0, 0, ROWS - 1, 1'b0, "R6 clamp low");

    // R7: single-row and partial slices
    scramble();
    run_period(1'b0, 3, 3, 1'b0, "R7 single row");
    scramble();
    run_period(1'b1, 5, 7, 1'b0, "R7 upper slice");

    // R9: second start during a walk is ignored
    scramble();
    run_period(1'b1, 2, 4, 1'b1, "R9 start while busy");

    // R9: invalid range ignored
    @(negedge clk);
    row_first = RW'(6); row_last = RW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 invalid range no busy", int'(busy), 0);
    compare_all("R9 invalid range no change");

    // R2: clear aborts a walk and wins over start
    scramble();
    @(negedge clk);
    row_first = '0; row_last = RW'(ROWS - 1); start = 1'b1; track_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1; start = 1'b1;
    @(negedge clk);
    clr = 1'b0; start = 1'b0;
    check("R2 clear stops walk", int'(busy), 0);
    check("R2 clear no done", int'(done), 0);
    zero_model();
    compare_all("R2 clear during walk");

    // random training then tracking with random slices
    for (int k = 0; k < 30; k++) begin
      int f, l;
      f = int'($urandom_range(ROWS - 1, 0));
      l = int'($urandom_range(ROWS - 1, f));
      scramble();
      run_period(k >= 6 ? 1'($urandom_range(1, 0)) : 1'b0, f, l, 1'b0,
                 "R3 R4 R5 R10 R11 random walk");
    end

    summary();
    $finish;
  end
endmodule